// File: doc/BRIEF.md
# Time Snapshot Register Interface

This block is the 32-bit register front end of a time-of-day counter. The counter keeps seconds in 48 bits plus a 32-bit nanoseconds word. Software reaches that time through three word registers: seconds high, seconds low and nanoseconds. Reading the nanoseconds word freezes the seconds count into a holding register. The two seconds words read after it therefore belong to the same instant. Writes to the seconds words are only held in staging registers. The counter receives the full new time in one load pulse when the nanoseconds word is written.

Software reads nanoseconds first and then the seconds words. It writes the seconds words first and nanoseconds last. The block also holds the counter's rate controls: the nominal period, a temporary adjust period with its cycle count, and a drift amount with its rate. A read-only word reports the counter clock frequency in Hz. The counter arithmetic sits outside this block and connects through the live-time, load and control ports.

The bus is a simple single-cycle port with byte address, write strobe, write data and read strobe. Read data is registered and appears one cycle after the read strobe.

Top module: `tod_reg_front`

## Requirements
- R1: After reset, read data is 0, no load or count-write pulse is active, the period output equals the PERIOD_RESET parameter, and adjust period and both drift outputs are 0.
- R2: A read of the nanoseconds word (0x108) returns the live nanoseconds value one cycle later and captures all 48 live seconds bits in the same cycle.
- R3: Reads of seconds low (0x104) and seconds high (0x100) return the captured seconds from the last nanoseconds read, even if the live time has moved since.
- R4: A seconds-high read returns captured seconds bits 47:32 in bits 15:0, with bits 31:16 reading as 0.
- R5: Writes to seconds high and seconds low only stage data and raise no load pulse. Only bits 15:0 of a seconds-high write are kept. A nanoseconds write raises load_o for exactly one cycle, in the next cycle, with load_sec_o = {staged high, staged low} and load_ns_o = written data.
- R6: Period (0x110), adjust period (0x114), drift amount (0x11C) and drift rate (0x120) are read/write. Only bits 19:0 of period and adjust period and bits 15:0 of the drift words are kept. Upper bits read as 0. Each output changes only on a write to its own address.
- R7: A write to adjust count (0x118) pulses adj_count_wr_o for one cycle, in the next cycle, with adj_count_o = write data bits 19:0. A read of 0x118 returns the live remaining count input and not the written value.
- R8: The word at 0x038 always reads CLK_FREQ_HZ. Writes to it have no effect.
- R9: Reads of any other byte address, including unaligned ones, return 0. Writes to them change no output and raise no pulse.
- R10: read data changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| live_sec_i | input | 48 | Running seconds count from the counter |
| live_ns_i | input | 32 | Running nanoseconds from the counter |
| load_o | output | 1 | One-cycle time load pulse |
| load_sec_o | output | 48 | Seconds to load |
| load_ns_o | output | 32 | Nanoseconds to load |
| period_o | output | PERIOD_W | Nominal period per clock |
| adj_period_o | output | PERIOD_W | Period used during an adjustment |
| adj_count_o | output | CNT_W | Adjustment cycle count to start |
| adj_count_wr_o | output | 1 | One-cycle start pulse for adj_count_o |
| adj_count_live_i | input | CNT_W | Remaining adjustment cycles from the counter |
| drift_amt_o | output | DRIFT_W | Drift correction amount |
| drift_rate_o | output | DRIFT_W | Drift correction interval |

## Verification
The hardest case is a torn timestamp: the live time moves between the nanoseconds read and the seconds reads that follow. The counter is not present, so the bench drives the live-time inputs directly. It changes them to bit-inverted values after every snapshot read, and each seconds read must still match the frozen values. A sweep over every byte address up to past the last register writes all-ones to the unmapped ones. After that sweep no output may change, no pulse may appear, and every mapped register must still read its old value.

// File: rtl/tod_reg_pkg.sv
package tod_reg_pkg;
  localparam int unsigned OFF_CLK_FREQ   = 32'h038;
  localparam int unsigned OFF_SEC_HI     = 32'h100;
  localparam int unsigned OFF_SEC_LO     = 32'h104;
  localparam int unsigned OFF_NS         = 32'h108;
  localparam int unsigned OFF_PERIOD     = 32'h110;
  localparam int unsigned OFF_ADJ_PER    = 32'h114;
  localparam int unsigned OFF_ADJ_CNT    = 32'h118;
  localparam int unsigned OFF_DRIFT_AMT  = 32'h11C;
  localparam int unsigned OFF_DRIFT_RATE = 32'h120;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_FREQ,
    SEL_SEC_HI,
    SEL_SEC_LO,
    SEL_NS,
    SEL_PERIOD,
    SEL_ADJ_PER,
    SEL_ADJ_CNT,
    SEL_DRIFT_AMT,
    SEL_DRIFT_RATE
  } reg_sel_e;
endpackage

// File: rtl/tod_addr_dec.sv
module tod_addr_dec
  import tod_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if      (addr_i == ADDR_W'(OFF_CLK_FREQ))   sel_o = SEL_FREQ;
    else if (addr_i == ADDR_W'(OFF_SEC_HI))     sel_o = SEL_SEC_HI;
    else if (addr_i == ADDR_W'(OFF_SEC_LO))     sel_o = SEL_SEC_LO;
    else if (addr_i == ADDR_W'(OFF_NS))         sel_o = SEL_NS;
    else if (addr_i == ADDR_W'(OFF_PERIOD))     sel_o = SEL_PERIOD;
    else if (addr_i == ADDR_W'(OFF_ADJ_PER))    sel_o = SEL_ADJ_PER;
    else if (addr_i == ADDR_W'(OFF_ADJ_CNT))    sel_o = SEL_ADJ_CNT;
    else if (addr_i == ADDR_W'(OFF_DRIFT_AMT))  sel_o = SEL_DRIFT_AMT;
    else if (addr_i == ADDR_W'(OFF_DRIFT_RATE)) sel_o = SEL_DRIFT_RATE;
  end
endmodule

// File: rtl/tod_time_shadow.sv
// Snapshot of live seconds on nanoseconds read; staged seconds committed on nanoseconds write.
module tod_time_shadow #(
  parameter int unsigned SEC_HI_W = 16,
  localparam int unsigned SEC_W   = 32 + SEC_HI_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_sec_hi_i,
  input  logic             wr_sec_lo_i,
  input  logic             wr_ns_i,
  input  logic             rd_ns_i,
  input  logic [31:0]      wdata_i,
  input  logic [SEC_W-1:0] live_sec_i,
  output logic [SEC_W-1:0] snap_sec_o,
  output logic             load_o,
  output logic [SEC_W-1:0] load_sec_o,
  output logic [31:0]      load_ns_o
);
  logic [SEC_HI_W-1:0] stage_hi_q;
  logic [31:0]         stage_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_sec_o <= '0;
      stage_hi_q <= '0;
      stage_lo_q <= '0;
      load_o     <= 1'b0;
      load_sec_o <= '0;
      load_ns_o  <= '0;
    end else begin
      load_o <= wr_ns_i;
      if (rd_ns_i)     snap_sec_o <= live_sec_i;
      if (wr_sec_hi_i) stage_hi_q <= wdata_i[SEC_HI_W-1:0];
      if (wr_sec_lo_i) stage_lo_q <= wdata_i;
      if (wr_ns_i) begin
        load_sec_o <= {stage_hi_q, stage_lo_q};
        load_ns_o  <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/tod_ctl_regs.sv
module tod_ctl_regs #(
  parameter int unsigned PERIOD_W          = 20,
  parameter int unsigned CNT_W             = 20,
  parameter int unsigned DRIFT_W           = 16,
  parameter logic [PERIOD_W-1:0] PERIOD_RST = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_period_i,
  input  logic                wr_adj_per_i,
  input  logic                wr_adj_cnt_i,
  input  logic                wr_drift_amt_i,
  input  logic                wr_drift_rate_i,
  input  logic [PERIOD_W-1:0] wdata_per_i,
  input  logic [CNT_W-1:0]    wdata_cnt_i,
  input  logic [DRIFT_W-1:0]  wdata_drift_i,
  output logic [PERIOD_W-1:0] period_o,
  output logic [PERIOD_W-1:0] adj_period_o,
  output logic [CNT_W-1:0]    adj_count_o,
  output logic                adj_count_wr_o,
  output logic [DRIFT_W-1:0]  drift_amt_o,
  output logic [DRIFT_W-1:0]  drift_rate_o
);
  // Two period-format registers share one structure.
  logic [1:0]               per_we;
  logic [PERIOD_W-1:0]      per_q [2];
  localparam logic [PERIOD_W-1:0] PER_RST [2] = '{PERIOD_RST, '0};

  assign per_we = {wr_adj_per_i, wr_period_i};

  for (genvar g = 0; g < 2; g++) begin : g_per
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        per_q[g] <= PER_RST[g];
      else if (per_we[g]) per_q[g] <= wdata_per_i;
    end
  end

  assign period_o     = per_q[0];
  assign adj_period_o = per_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adj_count_o    <= '0;
      adj_count_wr_o <= 1'b0;
      drift_amt_o    <= '0;
      drift_rate_o   <= '0;
    end else begin
      adj_count_wr_o <= wr_adj_cnt_i;
      if (wr_adj_cnt_i)    adj_count_o  <= wdata_cnt_i;
      if (wr_drift_amt_i)  drift_amt_o  <= wdata_drift_i;
      if (wr_drift_rate_i) drift_rate_o <= wdata_drift_i;
    end
  end
endmodule

// File: rtl/tod_reg_front.sv
module tod_reg_front
  import tod_reg_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned SEC_HI_W     = 16,
  parameter int unsigned PERIOD_W     = 20,
  parameter int unsigned CNT_W        = 20,
  parameter int unsigned DRIFT_W      = 16,
  parameter logic [31:0] CLK_FREQ_HZ  = 32'd100_000_000,
  parameter logic [31:0] PERIOD_RESET = 32'h000A_0000,
  localparam int unsigned SEC_W       = 32 + SEC_HI_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [31:0]         wdata_i,
  input  logic                rd_en_i,
  output logic [31:0]         rdata_o,
  input  logic [SEC_W-1:0]    live_sec_i,
  input  logic [31:0]         live_ns_i,
  output logic                load_o,
  output logic [SEC_W-1:0]    load_sec_o,
  output logic [31:0]         load_ns_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic [PERIOD_W-1:0] adj_period_o,
  output logic [CNT_W-1:0]    adj_count_o,
  output logic                adj_count_wr_o,
  input  logic [CNT_W-1:0]    adj_count_live_i,
  output logic [DRIFT_W-1:0]  drift_amt_o,
  output logic [DRIFT_W-1:0]  drift_rate_o
);
  reg_sel_e         sel;
  logic [SEC_W-1:0] snap_sec;
  logic [31:0]      rd_mux;

  tod_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  tod_time_shadow #(.SEC_HI_W(SEC_HI_W)) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_sec_hi_i (wr_en_i && sel == SEL_SEC_HI),
    .wr_sec_lo_i (wr_en_i && sel == SEL_SEC_LO),
    .wr_ns_i     (wr_en_i && sel == SEL_NS),
    .rd_ns_i     (rd_en_i && sel == SEL_NS),
    .wdata_i     (wdata_i),
    .live_sec_i  (live_sec_i),
    .snap_sec_o  (snap_sec),
    .load_o      (load_o),
    .load_sec_o  (load_sec_o),
    .load_ns_o   (load_ns_o)
  );

  tod_ctl_regs #(
    .PERIOD_W   (PERIOD_W),
    .CNT_W      (CNT_W),
    .DRIFT_W    (DRIFT_W),
    .PERIOD_RST (PERIOD_W'(PERIOD_RESET))
  ) u_ctl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wr_period_i     (wr_en_i && sel == SEL_PERIOD),
    .wr_adj_per_i    (wr_en_i && sel == SEL_ADJ_PER),
    .wr_adj_cnt_i    (wr_en_i && sel == SEL_ADJ_CNT),
    .wr_drift_amt_i  (wr_en_i && sel == SEL_DRIFT_AMT),
    .wr_drift_rate_i (wr_en_i && sel == SEL_DRIFT_RATE),
    .wdata_per_i     (wdata_i[PERIOD_W-1:0]),
    .wdata_cnt_i     (wdata_i[CNT_W-1:0]),
    .wdata_drift_i   (wdata_i[DRIFT_W-1:0]),
    .period_o        (period_o),
    .adj_period_o    (adj_period_o),
    .adj_count_o     (adj_count_o),
    .adj_count_wr_o  (adj_count_wr_o),
    .drift_amt_o     (drift_amt_o),
    .drift_rate_o    (drift_rate_o)
  );

  always_comb begin
    unique case (sel)
      SEL_FREQ:       rd_mux = CLK_FREQ_HZ;
      SEL_SEC_HI:     rd_mux = 32'(snap_sec[SEC_W-1:32]);
      SEL_SEC_LO:     rd_mux = snap_sec[31:0];
      SEL_NS:         rd_mux = live_ns_i;
      SEL_PERIOD:     rd_mux = 32'(period_o);
      SEL_ADJ_PER:    rd_mux = 32'(adj_period_o);
      SEL_ADJ_CNT:    rd_mux = 32'(adj_count_live_i);
      SEL_DRIFT_AMT:  rd_mux = 32'(drift_amt_o);
      SEL_DRIFT_RATE: rd_mux = 32'(drift_rate_o);
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/tod_reg_front_chk.sv
module tod_reg_front_chk
  import tod_reg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SEC_HI_W    = 16,
  parameter int unsigned PERIOD_W    = 20,
  parameter int unsigned CNT_W       = 20,
  parameter logic [31:0] CLK_FREQ_HZ = 32'd100_000_000
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                wr_en_i,
  input logic [31:0]         wdata_i,
  input logic                rd_en_i,
  input logic [31:0]         rdata_o,
  input logic [31:0]         live_ns_i,
  input logic                load_o,
  input logic [PERIOD_W-1:0] period_o,
  input logic [CNT_W-1:0]    adj_count_o,
  input logic                adj_count_wr_o
);
  logic at_ns, at_hi, at_per, at_cnt, at_freq;
  assign at_ns   = addr_i == ADDR_W'(OFF_NS);
  assign at_hi   = addr_i == ADDR_W'(OFF_SEC_HI);
  assign at_per  = addr_i == ADDR_W'(OFF_PERIOD);
  assign at_cnt  = addr_i == ADDR_W'(OFF_ADJ_CNT);
  assign at_freq = addr_i == ADDR_W'(OFF_CLK_FREQ);

  // R2
  ns_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && at_ns |=> rdata_o == $past(live_ns_i));

  // R4
  sec_hi_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && at_hi |=> rdata_o[31:SEC_HI_W] == '0);

  // R5
  load_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && at_ns |=> load_o);

  // R5
  load_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $past(wr_en_i && at_ns));

  // R6
  period_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && at_per) |=> $stable(period_o));

  // R7
  cnt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && at_cnt |=> adj_count_wr_o && adj_count_o == $past(wdata_i[CNT_W-1:0]));

  // R8
  freq_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && at_freq |=> rdata_o == CLK_FREQ_HZ);

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind tod_reg_front tod_reg_front_chk #(
  .ADDR_W      (ADDR_W),
  .SEC_HI_W    (SEC_HI_W),
  .PERIOD_W    (PERIOD_W),
  .CNT_W       (CNT_W),
  .CLK_FREQ_HZ (CLK_FREQ_HZ)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .addr_i         (addr_i),
  .wr_en_i        (wr_en_i),
  .wdata_i        (wdata_i),
  .rd_en_i        (rd_en_i),
  .rdata_o        (rdata_o),
  .live_ns_i      (live_ns_i),
  .load_o         (load_o),
  .period_o       (period_o),
  .adj_count_o    (adj_count_o),
  .adj_count_wr_o (adj_count_wr_o)
);

// File: tb/tod_reg_front_test.sv
module tod_reg_front_test;
  localparam int unsigned AW = 12;
  localparam logic [31:0] FREQ = 32'd100_000_000;
  localparam logic [31:0] PRST = 32'h000A_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic [47:0] live_sec = '0;
  logic [31:0] live_ns = '0;
  logic        load;
  logic [47:0] load_sec;
  logic [31:0] load_ns;
  logic [19:0] period, adj_period, adj_count, cnt_live = '0;
  logic        cnt_wr;
  logic [15:0] drift_amt, drift_rate;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tod_reg_front uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .live_sec_i(live_sec), .live_ns_i(live_ns),
    .load_o(load), .load_sec_o(load_sec), .load_ns_o(load_ns), .period_o(period),
    .adj_period_o(adj_period), .adj_count_o(adj_count), .adj_count_wr_o(cnt_wr),
    .adj_count_live_i(cnt_live), .drift_amt_o(drift_amt), .drift_rate_o(drift_rate)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int unsigned a, input logic [31:0] d);
    @(negedge clk); addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input int unsigned a, output logic [31:0] d);
    @(negedge clk); addr = AW'(a); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  function automatic bit mapped(input int unsigned a);
    return a == 32'h038 || a == 32'h100 || a == 32'h104 || a == 32'h108 ||
           a == 32'h110 || a == 32'h114 || a == 32'h118 || a == 32'h11C || a == 32'h120;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [47:0] sec, old_sec;
    logic [31:0] ns, old_ns;
    logic        pulse_seen;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 load", load, 0);
    chk("R1 cnt_wr", cnt_wr, 0);
    chk("R1 period", period, PRST[19:0]);
    chk("R1 adj_period", adj_period, 0);
    chk("R1 drift", {drift_amt, drift_rate}, 0);
    rst_n = 1'b1;

    // R2 R3 R4: snapshot coherence while live time moves
    for (int i = 0; i < 10; i++) begin
      sec = (48'h1 << (i * 5)) - 48'h1 ^ (48'hFFFF_0000_0000 >> i);
      ns  = 32'((i * 98765431) % 1000000000);
      live_sec = sec; live_ns = ns;
      bus_rd(32'h108, d);
      chk("R2 ns", d, ns);
      old_sec = sec;
      live_sec = ~sec; live_ns = ~ns;
      bus_rd(32'h104, d);
      chk("R3 sec_lo", d, old_sec[31:0]);
      live_sec = sec + 48'd7;
      bus_rd(32'h100, d);
      chk("R4 sec_hi", d, {16'h0, old_sec[47:32]});
      bus_rd(32'h104, d);
      chk("R3 sec_lo reread", d, old_sec[31:0]);
    end
    live_sec = 48'hFFFF_FFFF_FFFF; live_ns = 32'd999_999_999;
    bus_rd(32'h108, d);
    chk("R2 ns max", d, 32'd999_999_999);
    bus_rd(32'h100, d);
    chk("R4 sec_hi max", d, 32'h0000_FFFF);

    // R5 staged write, commit on nanoseconds
    for (int i = 0; i < 8; i++) begin
      sec = 48'h1234_5678_9ABC * (i + 1);
      ns  = 32'(i * 125000001);
      bus_wr(32'h100, {16'hDEAD ^ 16'(i), sec[47:32]});
      chk("R5 no load hi", load, 0);
      bus_wr(32'h104, sec[31:0]);
      chk("R5 no load lo", load, 0);
      bus_wr(32'h108, ns);
      chk("R5 load pulse", load, 1);
      chk("R5 load_sec", load_sec, sec);
      chk("R5 load_ns", load_ns, ns);
      @(negedge clk);
      chk("R5 load one cycle", load, 0);
    end
    // R5 reload of stage without rewriting seconds: staging is kept
    bus_wr(32'h108, 32'h5);
    chk("R5 stage kept", load_sec, 48'h1234_5678_9ABC * 8);

    // R6 masked control registers
    bus_wr(32'h110, 32'hFFFF_FFFF);
    bus_rd(32'h110, d);
    chk("R6 period mask", d, 32'h000F_FFFF);
    bus_wr(32'h114, 32'hFFFF_FFFF);
    bus_rd(32'h114, d);
    chk("R6 adj_per mask", d, 32'h000F_FFFF);
    bus_wr(32'h11C, 32'hFFFF_FFFF);
    bus_rd(32'h11C, d);
    chk("R6 drift_amt mask", d, 32'h0000_FFFF);
    bus_wr(32'h120, 32'hFFFF_FFFF);
    bus_rd(32'h120, d);
    chk("R6 drift_rate mask", d, 32'h0000_FFFF);
    bus_wr(32'h110, 32'h1234_5678);
    chk("R6 period out", period, 20'h45678);
    chk("R6 adj_per unchanged", adj_period, 20'hFFFFF);
    bus_wr(32'h114, 32'h000A_1111);
    chk("R6 adj_per out", adj_period, 20'hA1111);
    bus_wr(32'h11C, 32'hABCD_0042);
    chk("R6 drift_amt out", drift_amt, 16'h0042);
    chk("R6 drift_rate unchanged", drift_rate, 16'hFFFF);
    bus_wr(32'h120, 32'h0000_0311);
    chk("R6 drift_rate out", drift_rate, 16'h0311);

    // R7 adjust count write pulse vs live readback
    cnt_live = 20'd12345;
    bus_wr(32'h118, 32'hABC0_7777);
    chk("R7 cnt pulse", cnt_wr, 1);
    chk("R7 cnt value", adj_count, 20'h07777);
    @(negedge clk);
    chk("R7 cnt pulse one cycle", cnt_wr, 0);
    bus_rd(32'h118, d);
    chk("R7 live read", d, 32'd12345);
    cnt_live = 20'd0;
    bus_rd(32'h118, d);
    chk("R7 live zero", d, 0);

    // R8 frequency word read-only
    bus_wr(32'h038, 32'h0);
    bus_rd(32'h038, d);
    chk("R8 freq", d, FREQ);

    // R9 sweep every byte address: unmapped writes inert, reads zero
    pulse_seen = 0;
    for (int a = 0; a < 32'h140; a++) begin
      if (!mapped(a)) begin
        bus_wr(a, 32'hFFFF_FFFF);
        pulse_seen |= load | cnt_wr;
        bus_rd(a, d);
        if (d != 0) chk("R9 unmapped read", d, 0);
      end
    end
    chk("R9 no pulse", pulse_seen, 0);
    chk("R9 outputs kept", {period, adj_period, drift_amt, drift_rate, adj_count},
        {20'h45678, 20'hA1111, 16'h0042, 16'h0311, 20'h07777});
    bus_rd(32'h100, d);
    chk("R9 sec_hi kept", d, 32'h0000_FFFF);
    bus_wr(32'h108, 32'h9);
    chk("R9 stage kept", load_sec, 48'h1234_5678_9ABC * 8);

    // R10 read data holds without a read strobe
    bus_rd(32'h038, d);
    live_ns = 32'h1357_9BDF;
    bus_wr(32'h110, 32'h0);
    repeat (4) @(negedge clk);
    chk("R10 hold", rdata, FREQ);

    finish_run();
  end
endmodule